// File: doc/BRIEF.md
# Debug Cross-Trigger Unit with Peripheral Freeze

This block lets several subsystems of a chip stop and resume together during debug. Eight trigger inputs (core halt requests, trace events, peripheral status) each feed any combination of four broadcast channels through a per-input channel mask. The channels then reach eight trigger outputs through a second set of per-output masks. Channel events also leave on a matrix port and arrive from it, so that interfaces on other subsystems share the same four channels.

Selected outputs can be made sticky. A sticky output that has been raised stays high until software acknowledges it or an event arrives on a designated run channel. Output 0 also drives a peripheral freeze line. PWM timers, GPIO sequencers and similar blocks stop on the same cycle when a core enters debug halt, and start again together when the core leaves it. Software can raise a channel directly, and a single global enable gates all propagation. Configuration goes through a plain write port with a 3-bit address.

Top module: `xtrig_unit`

## Requirements
- R1: After reset, `trig_o`, `chan_out_o` and `periph_freeze_o` are all low, the global enable is clear and every mask is zero.
- R2: A write is captured at the rising edge where `cfg_we_i` is high. Address 0 is control: bit 0 is the global enable, bits 7:4 are the run-channel mask and bits 15:8 are the sticky-output mask. Address 1 holds the input map, with input i in bits 4i+3:4i and bit c of that nibble selecting channel c. Address 2 holds the output map in the same layout. Address 3 is the acknowledge register, where writing 1 to bit j acknowledges output j. Address 4 is channel-set, where bit c raises channel c.
- R3: Each `trig_i` bit passes through a two-flop synchronizer and is edge-detected. One rising edge produces exactly one one-cycle event, and a level that is held produces no further event. The event appears on `chan_out_o` after the third rising edge counted from the edge that first samples the input high, and on `trig_o` after the fourth.
- R4: An input whose nibble in the input map has several bits set raises all of those channels in the same cycle.
- R5: An output is set when any channel enabled in its output-map nibble is active. A non-sticky output is high for exactly one cycle per event.
- R6: A channel-set write, or a one-cycle pulse on `chan_in_i`, reaches `trig_o` after the second rising edge, counting the edge that captures it. Events from `chan_in_i` are not repeated on `chan_out_o`. Channel-set events are.
- R7: A sticky output stays high until one of two things happens. An acknowledge write for that output clears it at the capturing edge. An event on a channel in the run mask clears it on the edge after the event.
- R8: When a set and a clear (acknowledge or run event) reach one output on the same edge, the set wins and the output stays high.
- R9: While the global enable is clear, no channel event forms and every trigger output is cleared on the next edge, sticky outputs included.
- R10: `periph_freeze_o` equals trigger output 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 8 | Trigger inputs from subsystems, asynchronous |
| chan_in_i | input | 4 | Channel events arriving from the channel matrix |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| trig_o | output | 8 | Trigger outputs to subsystems |
| chan_out_o | output | 4 | Locally raised channel events toward the matrix |
| periph_freeze_o | output | 1 | Synchronous halt/run control for peripherals |

## Verification
The set and clear paths of a sticky output can meet on one edge. The bench provokes this in two ways. First, it writes an acknowledge on the exact edge at which a channel-set write from the previous cycle raises the halt output. Second, it raises the halt channel and the run channel in one channel-set write. In both cases the output must still be high afterwards, and a later plain acknowledge must bring it low. A scoreboard holds the expected output bits, each tagged with the cycle it is due, and compares them against the outputs sampled at the falling clock edge.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int N_TRIG  = 8;
  localparam int N_CHAN  = 4;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int RUN_LSB = 4;
  localparam int STK_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_INMAP  = 3'd1,
    A_OUTMAP = 3'd2,
    A_ACK    = 3'd3,
    A_CHSET  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/xtrig_regs.sv
module xtrig_regs
  import xtrig_pkg::*;
#(
  parameter int NT = N_TRIG,
  parameter int NC = N_CHAN
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  en_o,
  output logic [NC-1:0]         run_mask_o,
  output logic [NT-1:0]         sticky_o,
  output logic [NT-1:0][NC-1:0] in_map_o,
  output logic [NT-1:0][NC-1:0] out_map_o,
  output logic [NT-1:0]         ack_o,
  output logic [NC-1:0]         chset_o
);
  localparam int MAP_W = NT * NC;

  logic                  en_q;
  logic [NC-1:0]         run_q;
  logic [NT-1:0]         stk_q;
  logic [NT-1:0][NC-1:0] in_q;
  logic [NT-1:0][NC-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= '0;
      stk_q <= '0;
      in_q  <= '0;
      out_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          en_q  <= wdata_i[0];
          run_q <= wdata_i[RUN_LSB +: NC];
          stk_q <= wdata_i[STK_LSB +: NT];
        end
        A_INMAP:  in_q  <= wdata_i[MAP_W-1:0];
        A_OUTMAP: out_q <= wdata_i[MAP_W-1:0];
        default: ;
      endcase
    end
  end

  // write pulses act at the capturing edge
  assign ack_o   = (we_i && addr_i == A_ACK)   ? wdata_i[NT-1:0] : '0;
  assign chset_o = (we_i && addr_i == A_CHSET) ? wdata_i[NC-1:0] : '0;

  assign en_o       = en_q;
  assign run_mask_o = run_q;
  assign sticky_o   = stk_q;
  assign in_map_o   = in_q;
  assign out_map_o  = out_q;
endmodule

// File: rtl/xtrig_in_stage.sv
module xtrig_in_stage #(
  parameter int NT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NT-1:0] trig_i,
  output logic [NT-1:0] edge_o
);
  for (genvar i = 0; i < NT; i++) begin : g_in
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= trig_i[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign edge_o[i] = s2_q & ~prev_q;
  end
endmodule

// File: rtl/xtrig_chan_hub.sv
module xtrig_chan_hub #(
  parameter int NT = 8,
  parameter int NC = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NT-1:0]         edge_i,
  input  logic [NT-1:0][NC-1:0] in_map_i,
  input  logic [NC-1:0]         chset_i,
  input  logic [NC-1:0]         chan_in_i,
  output logic [NC-1:0]         act_o,
  output logic [NC-1:0]         loc_o
);
  logic [NC-1:0] raw;
  logic [NC-1:0] act_q, loc_q;

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [NT-1:0] hit;
    for (genvar i = 0; i < NT; i++) begin : g_src
      assign hit[i] = edge_i[i] & in_map_i[i][c];
    end
    assign raw[c] = |hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      loc_q <= '0;
    end else if (!en_i) begin
      act_q <= '0;
      loc_q <= '0;
    end else begin
      loc_q <= raw | chset_i;
      act_q <= raw | chset_i | chan_in_i;
    end
  end

  assign act_o = act_q;
  assign loc_o = loc_q;
endmodule

// File: rtl/xtrig_out_stage.sv
module xtrig_out_stage #(
  parameter int NT = 8,
  parameter int NC = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [NC-1:0]         act_i,
  input  logic [NT-1:0][NC-1:0] out_map_i,
  input  logic [NT-1:0]         sticky_i,
  input  logic [NC-1:0]         run_mask_i,
  input  logic [NT-1:0]         ack_i,
  output logic [NT-1:0]         trig_o
);
  logic run_hit;
  assign run_hit = |(act_i & run_mask_i);

  for (genvar j = 0; j < NT; j++) begin : g_out
    logic set, clr, q;
    assign set = |(act_i & out_map_i[j]);
    assign clr = ack_i[j] | run_hit;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q <= 1'b0;
      else if (!en_i)        q <= 1'b0;
      else if (set)          q <= 1'b1;  // set beats clear
      else if (!sticky_i[j]) q <= 1'b0;
      else if (clr)          q <= 1'b0;
    end
    assign trig_o[j] = q;
  end
endmodule

// File: rtl/xtrig_unit.sv
module xtrig_unit
  import xtrig_pkg::*;
#(
  parameter int NT       = N_TRIG,
  parameter int NC       = N_CHAN,
  parameter int HALT_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NT-1:0]     trig_i,
  input  logic [NC-1:0]     chan_in_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [NT-1:0]     trig_o,
  output logic [NC-1:0]     chan_out_o,
  output logic              periph_freeze_o
);
  logic                  glb_en;
  logic [NC-1:0]         run_mask;
  logic [NT-1:0]         sticky_mask;
  logic [NT-1:0][NC-1:0] in_map;
  logic [NT-1:0][NC-1:0] out_map;
  logic [NT-1:0]         ack_pulse;
  logic [NC-1:0]         chset_pulse;
  logic [NT-1:0]         trig_edge;
  logic [NC-1:0]         chan_act;

  xtrig_regs #(.NT(NT), .NC(NC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .en_o       (glb_en),
    .run_mask_o (run_mask),
    .sticky_o   (sticky_mask),
    .in_map_o   (in_map),
    .out_map_o  (out_map),
    .ack_o      (ack_pulse),
    .chset_o    (chset_pulse)
  );

  xtrig_in_stage #(.NT(NT)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  xtrig_chan_hub #(.NT(NT), .NC(NC)) u_hub (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (glb_en),
    .edge_i    (trig_edge),
    .in_map_i  (in_map),
    .chset_i   (chset_pulse),
    .chan_in_i (chan_in_i),
    .act_o     (chan_act),
    .loc_o     (chan_out_o)
  );

  xtrig_out_stage #(.NT(NT), .NC(NC)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (glb_en),
    .act_i      (chan_act),
    .out_map_i  (out_map),
    .sticky_i   (sticky_mask),
    .run_mask_i (run_mask),
    .ack_i      (ack_pulse),
    .trig_o     (trig_o)
  );

  assign periph_freeze_o = trig_o[HALT_IDX];
endmodule

// File: rtl/xtrig_unit_chk.sv
module xtrig_unit_chk #(
  parameter int NT = 8,
  parameter int NC = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  glb_en,
  input logic [NC-1:0]         run_mask,
  input logic [NT-1:0]         sticky_mask,
  input logic [NT-1:0][NC-1:0] out_map,
  input logic [NT-1:0]         ack_pulse,
  input logic [NC-1:0]         chset_pulse,
  input logic [NC-1:0]         chan_act,
  input logic [NC-1:0]         chan_out_o,
  input logic [NT-1:0]         trig_o
);
  p_gate_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> trig_o == '0);

  p_chset_reach_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glb_en && chset_pulse != '0) |=> (chan_out_o & $past(chset_pulse)) == $past(chset_pulse));

  for (genvar j = 0; j < NT; j++) begin : g_chk
    p_sticky_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glb_en && sticky_mask[j] && trig_o[j] && !ack_pulse[j] && ((chan_act & run_mask) == '0))
      |=> trig_o[j]);

    p_ack_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_pulse[j] && ((chan_act & out_map[j]) == '0)) |=> !trig_o[j]);

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (glb_en && ((chan_act & out_map[j]) != '0)) |=> trig_o[j]);

    p_has_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(trig_o[j]) |-> $past((chan_act & out_map[j]) != '0));
  end
endmodule

bind xtrig_unit xtrig_unit_chk #(.NT(NT), .NC(NC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .glb_en      (glb_en),
  .run_mask    (run_mask),
  .sticky_mask (sticky_mask),
  .out_map     (out_map),
  .ack_pulse   (ack_pulse),
  .chset_pulse (chset_pulse),
  .chan_act    (chan_act),
  .chan_out_o  (chan_out_o),
  .trig_o      (trig_o)
);

// File: tb/xtrig_unit_tb_top.sv
module xtrig_unit_tb_top;
  import xtrig_pkg::*;

  localparam int T0 = 1 << 0, T1 = 1 << 1, T2 = 1 << 2, T3 = 1 << 3, T4 = 1 << 4;
  localparam int C0 = 1 << 8, C1 = 1 << 9, C2 = 1 << 10, C3 = 1 << 11;
  localparam int FZ = 1 << 12;

  typedef struct {
    int          due;
    logic [12:0] mask;
    logic [12:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_i = '0;
  logic [3:0]  chan_in = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [7:0]  trig_o;
  logic [3:0]  chan_out;
  logic        freeze;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xtrig_unit dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .trig_i          (trig_i),
    .chan_in_i       (chan_in),
    .cfg_we_i        (we),
    .cfg_addr_i      (addr),
    .cfg_wdata_i     (wdata),
    .trig_o          (trig_o),
    .chan_out_o      (chan_out),
    .periph_freeze_o (freeze)
  );

  function automatic logic [12:0] obs();
    return {freeze, chan_out, trig_o};
  endfunction

  // due counted from the next rising edge (d = 0 is that edge)
  task automatic expect_at(int d, int mask, int exp, string req);
    item_t it;
    it.due = cyc + 1 + d;
    it.mask = 13'(mask);
    it.exp = 13'(exp);
    it.req = req;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          checks++;
          if ((obs() & sb[i].mask) != sb[i].exp) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h (mask %h)",
                     sb[i].req, cyc, obs() & sb[i].mask, sb[i].exp, sb[i].mask);
          end
          sb.delete(i);
        end
      end
    end
  end

  // called at a falling edge, returns at the falling edge after the write
  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (obs() != '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %h expected 0", obs());
    end
    rst_n = 1'b1;
    idle(1);

    // R2: enable, run channel 1, output 0 sticky; maps
    wr(A_CTRL, 32'h0000_0121);
    wr(A_INMAP, 32'h0000_0C21);
    wr(A_OUTMAP, 32'h0003_8421);
    idle(1);

    // R3/R5/R10: held input, one halt event
    expect_at(2, C0, C0, "R3");
    expect_at(3, T0 | T4 | FZ, T0 | T4 | FZ, "R5");
    expect_at(4, T0 | T4 | FZ | C0, T0 | FZ, "R7");
    expect_at(6, C0 | T0, T0, "R3");
    trig_i[0] = 1'b1;
    idle(8);

    // R7: acknowledge releases freeze at the write edge
    expect_at(0, T0 | FZ, 0, "R7");
    wr(A_ACK, 32'h1);
    idle(2);

    // R6: software halt, then run channel restarts
    expect_at(0, C0, C0, "R6");
    expect_at(1, T0 | FZ, T0 | FZ, "R6");
    wr(A_CHSET, 32'h1);
    idle(2);
    expect_at(1, T0 | T1 | T4 | FZ, T1 | T4, "R7");
    expect_at(2, T1, 0, "R5");
    wr(A_CHSET, 32'h2);
    idle(3);

    // R3: input must fall and rise again for a new event
    trig_i[0] = 1'b0;
    idle(3);
    expect_at(3, T0, T0, "R3");
    trig_i[0] = 1'b1;
    idle(5);
    expect_at(0, T0, 0, "R7");
    wr(A_ACK, 32'h1);
    idle(2);

    // R4: one input onto two channels
    expect_at(2, C2 | C3, C2 | C3, "R4");
    expect_at(3, T2 | T3 | T4, T2 | T3, "R4");
    trig_i[2] = 1'b1;
    idle(1);
    trig_i[2] = 1'b0;
    idle(6);

    // R6: matrix event reaches outputs, not forwarded
    expect_at(0, C3, 0, "R6");
    expect_at(1, T2 | T3, T3, "R6");
    chan_in = 4'h8;
    idle(1);
    chan_in = '0;
    idle(3);

    // R8: acknowledge on the edge the halt output sets
    expect_at(1, T0, T0, "R8");
    wr(A_CHSET, 32'h1);
    expect_at(0, T0, T0, "R8");
    expect_at(1, T0, T0, "R8");
    wr(A_ACK, 32'h1);
    idle(2);
    expect_at(0, T0, 0, "R7");
    wr(A_ACK, 32'h1);
    idle(2);

    // R8: halt and run channels in one write
    expect_at(1, T0 | T1, T0 | T1, "R8");
    expect_at(3, T0, T0, "R8");
    wr(A_CHSET, 32'h3);
    idle(4);
    expect_at(0, T0, 0, "R7");
    wr(A_ACK, 32'h1);
    idle(2);

    // R9: disabling clears a held halt and blocks new events
    expect_at(1, T0 | FZ, T0 | FZ, "R10");
    wr(A_CHSET, 32'h1);
    idle(2);
    expect_at(0, T0, T0, "R9");
    expect_at(1, T0 | FZ, 0, "R9");
    wr(A_CTRL, 32'h0000_0120);
    idle(2);
    expect_at(0, C0, 0, "R9");
    expect_at(1, 8'hFF, 0, "R9");
    wr(A_CHSET, 32'h1);
    idle(1);
    expect_at(2, C1, 0, "R9");
    expect_at(3, 8'hFF | FZ, 0, "R9");
    trig_i[1] = 1'b1;
    idle(6);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard left %0d items, expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule